// File: doc/BRIEF.md
# Arithmetic Flag and Branch Condition Unit

This block performs byte or word addition and subtraction and keeps a 16-bit
status word up to date. Arithmetic flags live at fixed bit positions: carry,
parity, half-carry, zero, sign and signed overflow. Three control flags sit
beside them: single-step, interrupt-enable and string direction. Software-style
strobes set or clear the control flags. No arithmetic result ever touches them.

A 4-bit condition selector is tested against the stored flags. The block then
reports whether a conditional jump would be taken. Signed, unsigned, equality,
sign, overflow and parity tests are all covered. A compare operation subtracts
and updates the flags, but leaves the result register alone. Every output is
registered, and the reset is synchronous and active high.

Top module: `arith_flag_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `result_o`, `flags_o` and `branch_o` all become zero after that edge.
- R2: With `op_valid` high, an add (`op_sel`=0) writes a+b to `result_o` after the edge. An add-with-carry (`op_sel`=1) writes a+b+`carry_in`. Carry, at bit 0 of `flags_o`, takes the carry out of the operand's top bit. `carry_in` is used only by codes 1 and 3.
- R3: A subtract (`op_sel`=2) writes a-b. A subtract-with-borrow (`op_sel`=3) writes a-b-`carry_in`. Carry (bit 0) is set when a borrow out of the top bit occurs.
- R4: Half-carry (bit 4) is set on a carry out of bit 3 during addition, or on a borrow into bit 3 during subtraction.
- R5: Overflow (bit 11) is set when the signed result falls outside the operand size's two's-complement range.
- R6: Zero (bit 6) is set when the sized result is all zeros. Sign (bit 7) equals the sized result's top bit: bit 7 for bytes and bit 15 for words.
- R7: Parity (bit 2) is set when the low 8 bits of the result hold an even number of ones, for both sizes.
- R8: A compare (`op_sel`=4) updates the six arithmetic flags as a subtraction would, and leaves `result_o` unchanged.
- R9: Single-step (bit 8), interrupt-enable (bit 9) and direction (bit 10) change only through `ctl_set`/`ctl_clr`. Index 0 of each strobe maps to bit 8, index 1 to bit 9 and index 2 to bit 10. A set wins over a clear in the same cycle.
- R10: Bits 1, 3, 5 and 12 to 15 of `flags_o` always read zero.
- R11: `branch_o` after an edge is the test selected by the `cond_i` value sampled at that edge, applied to `flags_o` as it was before that edge. An odd code is the complement of the even code below it. The even codes are: 0 overflow, 2 carry, 4 zero, 6 carry or zero, 8 sign, 10 parity, 12 sign xor overflow, and 14 (sign xor overflow) or zero.
- R12: With `size_word`=0 the operation uses the low bytes only, and `result_o[15:8]` reads zero.
- R13: With `op_valid` low, or with `op_sel` equal to 5, 6 or 7, neither `result_o` nor the arithmetic flags change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Perform the selected operation this cycle |
| op_sel | input | 3 | 0 add, 1 add+carry, 2 sub, 3 sub+borrow, 4 compare |
| size_word | input | 1 | 1 word, 0 byte |
| opa_i | input | 16 | First operand |
| opb_i | input | 16 | Second operand |
| carry_in | input | 1 | Carry/borrow input for codes 1 and 3 |
| ctl_set | input | 3 | Set strobes for bits 8, 9, 10 |
| ctl_clr | input | 3 | Clear strobes for bits 8, 9, 10 |
| cond_i | input | 4 | Branch condition selector |
| result_o | output | 16 | Registered result |
| flags_o | output | 16 | Flag register |
| branch_o | output | 1 | Registered branch-taken bit |

## Verification
The bench targets several corner cases:
- Byte and word results that wrap to zero.
- A signed overflow with no unsigned carry, and the reverse.
- A half-carry with no full carry.
- Borrow chains through `carry_in`.

Each of these catches a particular fault:
- A design that takes sign or carry from the wrong bit in byte mode gives wrong flags on `0x7F+1`.
- A design that computes parity over the whole word misreports word results with set upper bits.
- A compare that writes the result register changes `result_o`.

All sixteen condition codes are swept over several flag states, so a swapped signed/unsigned predicate shows up. The control-flag strobes are also driven alongside arithmetic, with set and clear asserted together.

// File: rtl/afu_pkg.sv
package afu_pkg;
  localparam int FLAG_W = 16;
  localparam int CTL_N  = 3;

  localparam int FL_CF = 0;
  localparam int FL_PF = 2;
  localparam int FL_AF = 4;
  localparam int FL_ZF = 6;
  localparam int FL_SF = 7;
  localparam int FL_TF = 8;
  localparam int FL_IF = 9;
  localparam int FL_DF = 10;
  localparam int FL_OF = 11;
  localparam int FL_CTL_BASE = FL_TF;

  localparam logic [FLAG_W-1:0] ARITH_MASK = 16'h08D5;
  localparam logic [FLAG_W-1:0] CTRL_MASK  = 16'h0700;
  localparam logic [FLAG_W-1:0] UNDEF_MASK = ~(ARITH_MASK | CTRL_MASK);

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_CMP = 3'd4
  } op_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } arith_flags_t;
endpackage

// File: rtl/flag_adder.sv
module flag_adder
  import afu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [W-1:0]  res_o,
  output arith_flags_t  fl_o
);
  localparam int MSB = W - 1;
  localparam int PAR_W = (W < 8) ? W : 8;

  logic [W:0] ext;

  always_comb begin
    if (sub_i) ext = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
    else       ext = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  end

  assign res_o = ext[W-1:0];

  always_comb begin
    fl_o.cf = ext[W];
    fl_o.pf = ~(^res_o[PAR_W-1:0]);
    fl_o.af = a_i[4] ^ b_i[4] ^ res_o[4];
    fl_o.zf = (res_o == '0);
    fl_o.sf = res_o[MSB];
    if (sub_i) fl_o.of = (a_i[MSB] != b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
    else       fl_o.of = (a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/flag_store.sv
module flag_store
  import afu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_i,
  input  arith_flags_t      new_i,
  input  logic [CTL_N-1:0]  set_i,
  input  logic [CTL_N-1:0]  clr_i,
  output logic [FLAG_W-1:0] flags_o
);
  arith_flags_t     ar_q;
  logic [CTL_N-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst)        ar_q <= '0;
    else if (upd_i) ar_q <= new_i;
  end

  for (genvar i = 0; i < CTL_N; i++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (rst)           ctl_q[i] <= 1'b0;
      else if (set_i[i]) ctl_q[i] <= 1'b1;
      else if (clr_i[i]) ctl_q[i] <= 1'b0;
    end
  end

  always_comb begin
    flags_o = '0;
    flags_o[FL_CF] = ar_q.cf;
    flags_o[FL_PF] = ar_q.pf;
    flags_o[FL_AF] = ar_q.af;
    flags_o[FL_ZF] = ar_q.zf;
    flags_o[FL_SF] = ar_q.sf;
    flags_o[FL_OF] = ar_q.of;
    flags_o[FL_CTL_BASE +: CTL_N] = ctl_q;
  end

  assert_ctl_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (set_i == '0 && clr_i == '0) |=> $stable(flags_o[FL_CTL_BASE +: CTL_N]));

  assert_ctl_set_R9: assert property (@(posedge clk) disable iff (rst)
    set_i[0] |=> flags_o[FL_TF]);

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (flags_o == '0));
endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import afu_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [3:0]        cond_i,
  output logic              taken_o
);
  logic cf, zf, sf, of, pf, base;

  assign cf = flags_i[FL_CF];
  assign zf = flags_i[FL_ZF];
  assign sf = flags_i[FL_SF];
  assign of = flags_i[FL_OF];
  assign pf = flags_i[FL_PF];

  always_comb begin
    unique case (cond_i[3:1])
      3'd0: base = of;
      3'd1: base = cf;
      3'd2: base = zf;
      3'd3: base = cf | zf;
      3'd4: base = sf;
      3'd5: base = pf;
      3'd6: base = sf ^ of;
      default: base = (sf ^ of) | zf;
    endcase
  end

  assign taken_o = base ^ cond_i[0];
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_sel,
  input  logic              size_word,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              carry_in,
  input  logic [CTL_N-1:0]  ctl_set,
  input  logic [CTL_N-1:0]  ctl_clr,
  input  logic [3:0]        cond_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              branch_o
);
  localparam int HI_W = DATA_W - BYTE_W;

  logic         legal, is_sub, use_cin, cin_eff, upd;
  logic [DATA_W-1:0] res_w, res_sel;
  logic [BYTE_W-1:0] res_b;
  arith_flags_t fl_w, fl_b, fl_sel;
  logic         taken_c;

  assign legal   = (op_sel <= OP_CMP);
  assign is_sub  = (op_sel == OP_SUB) || (op_sel == OP_SBB) || (op_sel == OP_CMP);
  assign use_cin = (op_sel == OP_ADC) || (op_sel == OP_SBB);
  assign cin_eff = use_cin & carry_in;
  assign upd     = op_valid & legal;

  flag_adder #(.W(DATA_W)) u_add_word (
    .a_i(opa_i), .b_i(opb_i), .cin_i(cin_eff), .sub_i(is_sub),
    .res_o(res_w), .fl_o(fl_w)
  );

  flag_adder #(.W(BYTE_W)) u_add_byte (
    .a_i(opa_i[BYTE_W-1:0]), .b_i(opb_i[BYTE_W-1:0]), .cin_i(cin_eff),
    .sub_i(is_sub), .res_o(res_b), .fl_o(fl_b)
  );

  assign res_sel = size_word ? res_w : {{HI_W{1'b0}}, res_b};
  assign fl_sel  = size_word ? fl_w : fl_b;

  always_ff @(posedge clk) begin
    if (rst)                             result_o <= '0;
    else if (upd && op_sel != OP_CMP)    result_o <= res_sel;
  end

  flag_store u_flags (
    .clk(clk), .rst(rst), .upd_i(upd), .new_i(fl_sel),
    .set_i(ctl_set), .clr_i(ctl_clr), .flags_o(flags_o)
  );

  branch_eval u_branch (
    .flags_i(flags_o), .cond_i(cond_i), .taken_o(taken_c)
  );

  always_ff @(posedge clk) begin
    if (rst) branch_o <= 1'b0;
    else     branch_o <= taken_c;
  end

  assert_cmp_keeps_result_R8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_CMP) |=> $stable(result_o));

  assert_zero_matches_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel < OP_CMP) |=> (flags_o[FL_ZF] == (result_o == '0)));

  assert_sign_matches_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel < OP_CMP) |=>
      (flags_o[FL_SF] == ($past(size_word) ? result_o[DATA_W-1] : result_o[BYTE_W-1])));

  assert_undef_zero_R10: assert property (@(posedge clk) disable iff (rst)
    ((flags_o & UNDEF_MASK) == '0));

  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && legal) |=> ($stable(result_o) && $stable(flags_o & ARITH_MASK)));

  assert_byte_upper_R12: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel < OP_CMP && !size_word) |=> (result_o[DATA_W-1:BYTE_W] == '0));

  assert_equal_code_R11: assert property (@(posedge clk) disable iff (rst)
    (cond_i == 4'd4) |=> (branch_o == $past(flags_o[FL_ZF])));
endmodule

// File: tb/arith_flag_unit_tb.sv
module arith_flag_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic        size_word = 1'b0;
  logic [15:0] opa_i = '0, opb_i = '0;
  logic        carry_in = 1'b0;
  logic [2:0]  ctl_set = '0, ctl_clr = '0;
  logic [3:0]  cond_i = '0;
  logic [15:0] result_o, flags_o;
  logic        branch_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  arith_flag_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .size_word(size_word), .opa_i(opa_i), .opb_i(opb_i), .carry_in(carry_in),
    .ctl_set(ctl_set), .ctl_clr(ctl_clr), .cond_i(cond_i),
    .result_o(result_o), .flags_o(flags_o), .branch_o(branch_o)
  );

  typedef struct {
    logic [15:0] res;
    logic [15:0] fl;
    logic        br;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_checks = 0, n_fail = 0;
  logic [15:0] m_res = '0, m_fl = '0;
  bit done = 0;

  function automatic logic model_branch(input logic [3:0] c, input logic [15:0] f);
    logic cf, pf, zf, sf, of;
    cf = f[0]; pf = f[2]; zf = f[6]; sf = f[7]; of = f[11];
    case (c)
      4'd0:  return of;
      4'd1:  return !of;
      4'd2:  return cf;
      4'd3:  return !cf;
      4'd4:  return zf;
      4'd5:  return !zf;
      4'd6:  return cf || zf;
      4'd7:  return !(cf || zf);
      4'd8:  return sf;
      4'd9:  return !sf;
      4'd10: return pf;
      4'd11: return !pf;
      4'd12: return sf != of;
      4'd13: return sf == of;
      4'd14: return (sf != of) || zf;
      default: return !((sf != of) || zf);
    endcase
  endfunction

  task automatic step(input bit r, input bit v, input int op, input bit w,
                      input logic [15:0] a, input logic [15:0] b, input bit ci,
                      input logic [2:0] s, input logic [2:0] cl,
                      input logic [3:0] c, input string tag);
    exp_t e;
    int   msb;
    logic [15:0] m, res;
    logic [16:0] r17;
    bit   cy, sub;
    @(negedge clk);
    rst = r; op_valid = v; op_sel = op[2:0]; size_word = w; opa_i = a; opb_i = b;
    carry_in = ci; ctl_set = s; ctl_clr = cl; cond_i = c;
    e.br = r ? 1'b0 : model_branch(c, m_fl);
    if (r) begin
      m_res = '0; m_fl = '0;
    end else begin
      if (v && op <= 4) begin
        m = w ? 16'hFFFF : 16'h00FF;
        msb = w ? 15 : 7;
        cy = (op == 1 || op == 3) ? ci : 1'b0;
        sub = (op >= 2);
        if (sub) r17 = {1'b0, a & m} - {1'b0, b & m} - {16'd0, cy};
        else     r17 = {1'b0, a & m} + {1'b0, b & m} + {16'd0, cy};
        res = r17[15:0] & m;
        m_fl[0]  = w ? r17[16] : r17[8];
        m_fl[2]  = ~(^res[7:0]);
        m_fl[4]  = a[4] ^ b[4] ^ res[4];
        m_fl[6]  = (res == 0);
        m_fl[7]  = res[msb];
        if (sub) m_fl[11] = (a[msb] != b[msb]) && (res[msb] != a[msb]);
        else     m_fl[11] = (a[msb] == b[msb]) && (res[msb] != a[msb]);
        if (op != 4) m_res = res;
      end
      for (int i = 0; i < 3; i++) begin
        if (s[i])       m_fl[8+i] = 1'b1;
        else if (cl[i]) m_fl[8+i] = 1'b0;
      end
    end
    e.res = m_res; e.fl = m_fl; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic op(input int o, input bit w, input logic [15:0] a,
                    input logic [15:0] b, input bit ci, input string tag);
    step(0, 1, o, w, a, b, ci, 3'b000, 3'b000, 4'd0, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_checks++;
        if (result_o !== e.res || flags_o !== e.fl || branch_o !== e.br) begin
          n_fail++;
          $display("FAIL %s: res=%h flags=%h br=%b expected res=%h flags=%h br=%b",
                   e.tag, result_o, flags_o, branch_o, e.res, e.fl, e.br);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : driver
    // R1: reset clears everything
    step(1, 0, 0, 0, 0, 0, 0, 3'b000, 3'b000, 4'd0, "R1");
    step(1, 1, 0, 1, 16'h1234, 16'h4321, 0, 3'b111, 3'b000, 4'd1, "R1");
    // R2 R5 R6 R12: byte 0x7F+1 -> signed overflow, sign from bit 7
    op(0, 0, 16'hAB7F, 16'hCD01, 0, "R5_R12");
    // R2 R6 R7: word wrap to zero
    op(0, 1, 16'hFFFF, 16'h0001, 0, "R2_R6");
    // R2: add-with-carry, and add ignoring carry_in
    op(1, 0, 16'h00F0, 16'h000F, 1, "R2");
    op(0, 0, 16'h00F0, 16'h000F, 1, "R2");
    // R4: half-carry without full carry
    op(0, 1, 16'h0008, 16'h0008, 0, "R4");
    // R3: borrow in byte and word, with borrow input
    op(2, 0, 16'h0000, 16'h0001, 0, "R3");
    op(3, 1, 16'h8000, 16'h0000, 1, "R3_R5");
    op(3, 1, 16'h0005, 16'h0005, 1, "R3");
    // R7: parity over low byte only for word results
    op(0, 1, 16'h7F00, 16'h0003, 0, "R7");
    op(0, 1, 16'h0100, 16'h0001, 0, "R7");
    // R8: compare updates flags, result stays
    op(4, 1, 16'h1234, 16'h1234, 0, "R8");
    op(4, 0, 16'h0010, 16'h0020, 0, "R8");
    // R13: idle and illegal codes leave state
    step(0, 0, 0, 1, 16'hFFFF, 16'hFFFF, 1, 3'b000, 3'b000, 4'd0, "R13");
    step(0, 1, 5, 1, 16'h0001, 16'h0001, 0, 3'b000, 3'b000, 4'd0, "R13");
    step(0, 1, 7, 0, 16'h0080, 16'h0080, 1, 3'b000, 3'b000, 4'd0, "R13");
    // R9: control flags via strobes only, set beats clear
    step(0, 0, 0, 0, 0, 0, 0, 3'b101, 3'b000, 4'd0, "R9");
    step(0, 1, 0, 1, 16'h0001, 16'h0001, 0, 3'b000, 3'b000, 4'd0, "R9_R10");
    step(0, 0, 0, 0, 0, 0, 0, 3'b010, 3'b111, 4'd0, "R9");
    step(0, 1, 2, 0, 16'h0003, 16'h0009, 0, 3'b000, 3'b010, 4'd0, "R9");
    // R11: sweep all codes over several flag states
    for (int k = 0; k < 5; k++) begin
      case (k)
        0: op(2, 1, 16'h0005, 16'h0005, 0, "R11_setup");
        1: op(2, 1, 16'h0003, 16'h0005, 0, "R11_setup");
        2: op(2, 0, 16'h0080, 16'h0001, 0, "R11_setup");
        3: op(0, 1, 16'h4000, 16'h0001, 0, "R11_setup");
        default: op(2, 0, 16'h0005, 16'h0003, 0, "R11_setup");
      endcase
      for (int c = 0; c < 16; c++)
        step(0, 0, 0, 0, 0, 0, 0, 3'b000, 3'b000, c[3:0], "R11");
    end
    // R11: branch uses flags before the same-cycle update
    op(2, 1, 16'h0001, 16'h0001, 0, "R11");
    step(0, 1, 0, 1, 16'h0001, 16'h0001, 0, 3'b000, 3'b000, 4'd4, "R11");
    step(0, 0, 0, 0, 0, 0, 0, 3'b000, 3'b000, 4'd4, "R11");
    // R1: reset after activity
    step(1, 0, 0, 0, 0, 0, 0, 3'b000, 3'b000, 4'd0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 3'b000, 3'b000, 4'd5, "R1");
    @(negedge clk);
    op_valid = 1'b0; ctl_set = '0; ctl_clr = '0;
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule